// File: doc/BRIEF.md
# Per-Line Stream CRC Tagger and Checker

This block sits inline on a pixel stream that uses valid/ready handshaking. Each packet on the stream carries one image line, and the first and last beats are marked. In tag mode the block computes a 32-bit CRC over the words of each line as they pass. After the line's last pixel it adds one extra beat that holds the CRC. The end-of-packet marker moves onto that added beat, so the line goes to external memory with its own checksum attached.

In check mode a line read back from memory enters with its CRC still attached. The block computes the CRC again over the payload words and removes the final beat, which is the stored CRC, from the output. It then compares the two values. On the first mismatch a sticky error flag rises and the index of the failing line is held. Lines are counted from a start-of-frame marker that comes with the first beat of a line. A fault anywhere on the path through memory therefore shows up when the line is read again.

The mode pin is expected to change only while the stream is idle between lines. Downstream back-pressure stalls the output register, and no beat and no CRC state is lost.

Top module: `lcrc_tagger`

## Requirements
- R1: The CRC uses polynomial 0x04C11DB7 with the register preset to all ones. It processes one word per beat, bit DATA_W-1 first and without reflection, and the result is XORed with all ones. It covers only the payload words of one line and restarts on each start-of-packet beat.
- R2: In tag mode every payload beat leaves unchanged with its start marker kept and its end marker cleared. One extra beat follows with the CRC in bits [31:0], zeros above, the start marker at 0 and the end marker at 1.
- R3: In tag mode a beat accepted at a clock edge is on the output from that edge on. The CRC beat is presented in the cycle right after the last payload beat leaves. Input ready is low in the cycle after the end beat is accepted.
- R4: In check mode the final beat of each packet is taken as the stored CRC and does not appear on the output. The payload beats leave in order, with the end marker on the last payload beat and the start marker kept.
- R5: In check mode, when the stored CRC differs from the one recomputed over the payload, the error flag is set one cycle after the CRC beat is accepted and stays set until reset. A matching CRC changes nothing.
- R6: The held line index is that of the first mismatching line. Line indices start at 0 after reset, return to 0 on a start beat flagged as start-of-frame, and otherwise rise by one with each packet.
- R7: While the output is valid and not ready, the output data and markers stay stable and no beat is lost. In tag mode input ready is low during that time.
- R8: After reset the output is not valid, input ready is high, the error flag is 0 and the held line index is 0.
- R9: In check mode a packet made of a single beat, which carries both markers, produces no output. It is compared against the CRC of an empty payload, 0x00000000.
- R10: In check mode a payload beat leaves at the edge that accepts the next beat of its packet. Under a ready output, a line's payload leaves on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_check | input | 1 | 0: append CRC, 1: verify and strip CRC |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Block accepts the input beat |
| s_data | input | DATA_W | Input word |
| s_sop | input | 1 | First beat of a line |
| s_eop | input | 1 | Last beat of a line |
| s_sof | input | 1 | With s_sop: line starts a frame |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Downstream accepts the output beat |
| m_data | output | DATA_W | Output word |
| m_sop | output | 1 | Output first beat of a line |
| m_eop | output | 1 | Output last beat of a line |
| err_flag | output | 1 | Sticky CRC mismatch flag |
| err_line | output | LINE_W | Index of the first mismatching line |

## Verification
In tag mode each output beat is due one edge after the input beat is accepted, and the CRC beat is due one edge after that. In check mode a payload beat is due at the edge that accepts the following beat, and the error flag is due one edge after the CRC beat. The bench drives inputs just after the falling edge and samples outputs one nanosecond later. Each output beat is stamped with its cycle number, so the spacing between beats can be checked as well as their content. The error state is read only after a fixed drain window that is longer than any line plus its stalls.

// File: rtl/lcrc_pkg.sv
package lcrc_pkg;
   localparam int CRC_W = 32;
   typedef logic [CRC_W-1:0] crc_t;
   typedef enum logic {
      LCRC_TAG   = 1'b0,
      LCRC_CHECK = 1'b1
   } lcrc_mode_e;
endpackage

// File: rtl/lcrc_engine.sv
module lcrc_engine
   import lcrc_pkg::*;
#(
   parameter int   DATA_W = 32,
   parameter crc_t POLY   = 32'h04C11DB7,
   parameter crc_t INIT   = 32'hFFFFFFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   input  logic              start,
   input  logic [DATA_W-1:0] din,
   output crc_t              crc_q,
   output crc_t              crc_base
);
   function automatic crc_t step(input crc_t c, input logic [DATA_W-1:0] d);
      crc_t r;
      logic fb;
      r = c;
      for (int i = DATA_W - 1; i >= 0; i--) begin
         fb = r[CRC_W-1] ^ d[i];
         r  = {r[CRC_W-2:0], 1'b0};
         if (fb) r = r ^ POLY;
      end
      return r;
   endfunction

   assign crc_base = start ? INIT : crc_q;

   always_ff @(posedge clk) begin
      if (!rst_n)   crc_q <= INIT;
      else if (adv) crc_q <= step(crc_base, din);
   end
endmodule

// File: rtl/lcrc_line_ctr.sv
module lcrc_line_ctr #(
   parameter int LINE_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sop_acc,
   input  logic              sof,
   output logic [LINE_W-1:0] line_now
);
   logic [LINE_W-1:0] cur;

   always_comb begin
      if (sop_acc) line_now = sof ? '0 : cur + LINE_W'(1);
      else         line_now = cur;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       cur <= '1;
      else if (sop_acc) cur <= line_now;
   end
endmodule

// File: rtl/lcrc_out_stage.sv
module lcrc_out_stage #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] ld_data,
   input  logic              ld_sop,
   input  logic              ld_eop,
   input  logic              m_ready,
   output logic              free,
   output logic              m_valid,
   output logic [DATA_W-1:0] m_data,
   output logic              m_sop,
   output logic              m_eop
);
   assign free = !m_valid || m_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         m_valid <= 1'b0;
         m_data  <= '0;
         m_sop   <= 1'b0;
         m_eop   <= 1'b0;
      end else if (load) begin
         m_valid <= 1'b1;
         m_data  <= ld_data;
         m_sop   <= ld_sop;
         m_eop   <= ld_eop;
      end else if (m_ready) begin
         m_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/lcrc_tagger.sv
module lcrc_tagger
   import lcrc_pkg::*;
#(
   parameter int   DATA_W = 32,
   parameter int   LINE_W = 12,
   parameter crc_t POLY   = 32'h04C11DB7,
   parameter crc_t INIT   = 32'hFFFFFFFF,
   parameter crc_t XOROUT = 32'hFFFFFFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_check,
   input  logic              s_valid,
   output logic              s_ready,
   input  logic [DATA_W-1:0] s_data,
   input  logic              s_sop,
   input  logic              s_eop,
   input  logic              s_sof,
   output logic              m_valid,
   input  logic              m_ready,
   output logic [DATA_W-1:0] m_data,
   output logic              m_sop,
   output logic              m_eop,
   output logic              err_flag,
   output logic [LINE_W-1:0] err_line
);
   if (DATA_W < CRC_W) begin : g_bad_width
      $error("lcrc_tagger: DATA_W must be at least the CRC width");
   end
   if (LINE_W < 1) begin : g_bad_line
      $error("lcrc_tagger: LINE_W must be at least 1");
   end

   lcrc_mode_e        mode;
   logic              acc;
   logic              o_free;
   logic              o_load;
   logic [DATA_W-1:0] o_data;
   logic              o_sop;
   logic              o_eop;
   logic              ins_pend;
   logic              ins_fire;
   logic              crc_adv;
   logic              crc_bad;
   logic              h_valid;
   logic [DATA_W-1:0] h_data;
   logic              h_sop;
   crc_t              crc_q;
   crc_t              crc_base;
   logic [DATA_W-1:0] crc_word;
   logic [LINE_W-1:0] line_now;

   assign mode = lcrc_mode_e'(mode_check);

   // input ready depends only on registers and m_ready
   assign s_ready = (mode == LCRC_TAG) ? (o_free && !ins_pend)
                                       : (!h_valid || o_free);
   assign acc      = s_valid && s_ready;
   assign ins_fire = (mode == LCRC_TAG) && ins_pend && o_free;

   if (DATA_W == CRC_W) begin : g_word_eq
      assign crc_word = crc_q ^ XOROUT;
   end else begin : g_word_pad
      assign crc_word = {{(DATA_W-CRC_W){1'b0}}, crc_q ^ XOROUT};
   end

   always_comb begin
      if (mode == LCRC_TAG) begin
         o_load  = acc || ins_fire;
         o_data  = ins_fire ? crc_word : s_data;
         o_sop   = !ins_fire && s_sop;
         o_eop   = ins_fire;
         crc_adv = acc;
      end else begin
         o_load  = acc && h_valid;
         o_data  = h_data;
         o_sop   = h_sop;
         o_eop   = s_eop;
         crc_adv = acc && !s_eop;
      end
   end

   assign crc_bad = (mode == LCRC_CHECK) && acc && s_eop &&
                    (s_data[CRC_W-1:0] != (crc_base ^ XOROUT));

   lcrc_engine #(
      .DATA_W (DATA_W),
      .POLY   (POLY),
      .INIT   (INIT)
   ) u_engine (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (crc_adv),
      .start    (s_sop),
      .din      (s_data),
      .crc_q    (crc_q),
      .crc_base (crc_base)
   );

   lcrc_line_ctr #(
      .LINE_W (LINE_W)
   ) u_line (
      .clk      (clk),
      .rst_n    (rst_n),
      .sop_acc  (acc && s_sop),
      .sof      (s_sof),
      .line_now (line_now)
   );

   lcrc_out_stage #(
      .DATA_W (DATA_W)
   ) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (o_load),
      .ld_data (o_data),
      .ld_sop  (o_sop),
      .ld_eop  (o_eop),
      .m_ready (m_ready),
      .free    (o_free),
      .m_valid (m_valid),
      .m_data  (m_data),
      .m_sop   (m_sop),
      .m_eop   (m_eop)
   );

   // tag mode: pending CRC insertion slot
   always_ff @(posedge clk) begin
      if (!rst_n)                                  ins_pend <= 1'b0;
      else if (mode == LCRC_TAG && acc && s_eop)   ins_pend <= 1'b1;
      else if (ins_fire)                           ins_pend <= 1'b0;
   end

   // check mode: one-beat hold so the trailing CRC beat can be dropped
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         h_valid <= 1'b0;
         h_data  <= '0;
         h_sop   <= 1'b0;
      end else if (mode == LCRC_CHECK && acc) begin
         if (s_eop) begin
            h_valid <= 1'b0;
         end else begin
            h_valid <= 1'b1;
            h_data  <= s_data;
            h_sop   <= s_sop;
         end
      end
   end

   // first-error capture
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         err_flag <= 1'b0;
         err_line <= '0;
      end else if (crc_bad && !err_flag) begin
         err_flag <= 1'b1;
         err_line <= line_now;
      end
   end
endmodule

// File: rtl/lcrc_tagger_chk.sv
module lcrc_tagger_chk #(
   parameter int DATA_W = 32,
   parameter int LINE_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mode_check,
   input logic              s_valid,
   input logic              s_ready,
   input logic              s_sop,
   input logic              s_eop,
   input logic              m_valid,
   input logic              m_ready,
   input logic [DATA_W-1:0] m_data,
   input logic              m_sop,
   input logic              m_eop,
   input logic              err_flag,
   input logic [LINE_W-1:0] err_line,
   input logic              crc_bad
);
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_sop) && $stable(m_eop));

   p_full_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_check && m_valid && !m_ready |-> !s_ready);

   p_tag_eop_moved_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_check && s_valid && s_ready && s_eop |=> m_valid && !m_eop);

   p_tag_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_check && s_valid && s_ready && s_eop |=> !s_ready);

   p_chk_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mode_check && s_valid && s_ready && s_eop && !s_sop |=> m_valid && m_eop);

   p_chk_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mode_check && s_valid && s_ready && s_eop && s_sop
      |=> m_valid == ($past(m_valid) && !$past(m_ready)));

   p_err_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      crc_bad |=> err_flag);

   p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |=> err_flag && $stable(err_line));
endmodule

bind lcrc_tagger lcrc_tagger_chk #(
   .DATA_W (DATA_W),
   .LINE_W (LINE_W)
) u_lcrc_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mode_check (mode_check),
   .s_valid    (s_valid),
   .s_ready    (s_ready),
   .s_sop      (s_sop),
   .s_eop      (s_eop),
   .m_valid    (m_valid),
   .m_ready    (m_ready),
   .m_data     (m_data),
   .m_sop      (m_sop),
   .m_eop      (m_eop),
   .err_flag   (err_flag),
   .err_line   (err_line),
   .crc_bad    (crc_bad)
);

// File: tb/lcrc_tagger_bench.sv
module lcrc_tagger_bench;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int DATA_W = 32;
   localparam int LINE_W = 12;
   localparam int WDOG   = 60000;

   typedef struct {
      logic [31:0] d;
      logic        sop;
      logic        eop;
      int          cyc;
   } beat_t;

   typedef struct packed {
      logic        chk;
      logic [7:0]  len;
      logic [15:0] seed;
      logic        bad;
      logic        sof;
      logic        stall;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 8'd4,  16'h1111, 1'b0, 1'b1, 1'b0},
      '{1'b0, 8'd1,  16'h2222, 1'b0, 1'b0, 1'b1},
      '{1'b0, 8'd7,  16'h3333, 1'b0, 1'b0, 1'b1},
      '{1'b1, 8'd3,  16'h4444, 1'b0, 1'b1, 1'b0},
      '{1'b1, 8'd5,  16'h5555, 1'b0, 1'b0, 1'b1},
      '{1'b1, 8'd2,  16'h6666, 1'b1, 1'b0, 1'b1},
      '{1'b1, 8'd6,  16'h7777, 1'b0, 1'b0, 1'b0},
      '{1'b1, 8'd4,  16'h8888, 1'b1, 1'b1, 1'b1},
      '{1'b0, 8'd16, 16'h9999, 1'b0, 1'b0, 1'b1}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              mode_check = 1'b0;
   logic              s_valid = 1'b0;
   logic              s_ready;
   logic [DATA_W-1:0] s_data = '0;
   logic              s_sop = 1'b0;
   logic              s_eop = 1'b0;
   logic              s_sof = 1'b0;
   logic              m_valid;
   logic              m_ready = 1'b1;
   logic [DATA_W-1:0] m_data;
   logic              m_sop;
   logic              m_eop;
   logic              err_flag;
   logic [LINE_W-1:0] err_line;

   int    n_checks = 0;
   int    n_errs   = 0;
   int    cyc      = 0;
   int    rdy_mode = 0;
   int    ln       = -1;
   bit    exp_err  = 1'b0;
   int    exp_line = 0;
   bit    done     = 1'b0;
   beat_t got[$];

   always #2 clk = ~clk;

   lcrc_tagger #(
      .DATA_W (DATA_W),
      .LINE_W (LINE_W)
   ) u_lcrc_tagger (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_check (mode_check),
      .s_valid    (s_valid),
      .s_ready    (s_ready),
      .s_data     (s_data),
      .s_sop      (s_sop),
      .s_eop      (s_eop),
      .s_sof      (s_sof),
      .m_valid    (m_valid),
      .m_ready    (m_ready),
      .m_data     (m_data),
      .m_sop      (m_sop),
      .m_eop      (m_eop),
      .err_flag   (err_flag),
      .err_line   (err_line)
   );

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc >= WDOG && !done) begin
         n_checks++;
         n_errs++;
         $display("FAIL watchdog R7: actual %0d cycles, expected fewer than %0d", cyc, WDOG);
         summary();
         $finish;
      end
   end

   always @(negedge clk) begin
      case (rdy_mode)
         0:       m_ready <= 1'b1;
         1:       m_ready <= (cyc % 3) != 1;
         default: m_ready <= 1'b0;
      endcase
   end

   always @(negedge clk) begin
      #1;
      if (rst_n && m_valid && m_ready) got.push_back('{m_data, m_sop, m_eop, cyc});
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_errs++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] crc_upd(input logic [31:0] c, input logic [31:0] d);
      logic [31:0] r;
      logic fb;
      r = c;
      for (int i = 31; i >= 0; i--) begin
         fb = r[31] ^ d[i];
         r  = {r[30:0], 1'b0};
         if (fb) r = r ^ 32'h04C11DB7;
      end
      return r;
   endfunction

   function automatic logic [31:0] gen(input logic [15:0] seed, input int i);
      return ({16'h0, seed} * 32'h9E3779B1) ^ (i * 32'h85EBCA77) ^ 32'(i);
   endfunction

   // called right after a falling edge; returns right after the falling edge following acceptance
   task automatic put(input logic [31:0] d, input bit sop, input bit eop, input bit sof);
      bit taken;
      s_valid = 1'b1;
      s_data  = d;
      s_sop   = sop;
      s_eop   = eop;
      s_sof   = sof;
      taken   = 1'b0;
      while (!taken) begin
         #1;
         taken = s_ready;
         @(negedge clk);
      end
      s_valid = 1'b0;
   endtask

   task automatic compare(ref beat_t e[$], input bit stall, input string req, input string treq);
      check(got.size() == e.size(), req, "beat count", got.size(), e.size());
      for (int i = 0; i < e.size() && i < got.size(); i++) begin
         check(got[i].d == e[i].d, (!mode_check && i == e.size() - 1) ? "R1" : req,
               "data", got[i].d, e[i].d);
         check(got[i].sop == e[i].sop, req, "sop", got[i].sop, e[i].sop);
         check(got[i].eop == e[i].eop, req, "eop", got[i].eop, e[i].eop);
         if (!stall && i > 0)
            check(got[i].cyc == got[i-1].cyc + 1, treq, "beat spacing",
                  got[i].cyc - got[i-1].cyc, 1);
      end
      got.delete();
   endtask

   task automatic run_line(input bit chk, input int len, input logic [15:0] seed,
                           input bit bad, input bit sof, input bit stall);
      logic [31:0] pl[64];
      logic [31:0] c;
      beat_t       e[$];
      rdy_mode   = stall ? 1 : 0;
      mode_check = chk;
      c = 32'hFFFFFFFF;
      for (int i = 0; i < len; i++) begin
         pl[i] = gen(seed, i);
         c = crc_upd(c, pl[i]);
      end
      c = c ^ 32'hFFFFFFFF;
      ln = sof ? 0 : ln + 1;
      if (!chk) begin
         for (int i = 0; i < len; i++) begin
            put(pl[i], i == 0, i == len - 1, sof && i == 0);
            e.push_back('{pl[i], i == 0, 1'b0, 0});
         end
         e.push_back('{c, 1'b0, 1'b1, 0});
      end else begin
         for (int i = 0; i < len; i++) begin
            put(pl[i], i == 0, 1'b0, sof && i == 0);
            e.push_back('{pl[i], i == 0, i == len - 1, 0});
         end
         put(c ^ (bad ? 32'h1 : 32'h0), len == 0, 1'b1, sof && len == 0);
         if (bad && !exp_err) begin
            exp_err  = 1'b1;
            exp_line = ln;
         end
      end
      repeat (50) @(negedge clk);
      compare(e, stall, chk ? "R4" : "R2", chk ? "R10" : "R3");
      check(err_flag == exp_err, "R5", "err_flag", err_flag, exp_err);
      check(err_line == LINE_W'(exp_line), "R6", "err_line", err_line, exp_line);
   endtask

   initial begin
      beat_t rt[$];
      beat_t e[$];
      logic [31:0] b0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      // R8: reset state
      check(m_valid == 1'b0, "R8", "m_valid", m_valid, 0);
      check(s_ready == 1'b1, "R8", "s_ready", s_ready, 1);
      check(err_flag == 1'b0, "R8", "err_flag", err_flag, 0);
      check(err_line == '0, "R8", "err_line", err_line, 0);
      @(negedge clk);

      // R9: CRC-only line with the empty-payload CRC (zero) -> no output, no error
      run_line(1'b1, 0, 16'h0, 1'b0, 1'b1, 1'b0);

      // R5 round trip: tag a line, then feed the tagged beats back in check mode
      run_line(1'b0, 5, 16'hABCD, 1'b0, 1'b0, 1'b0);
      for (int i = 0; i < 5; i++) rt.push_back('{gen(16'hABCD, i), i == 0, 1'b0, 0});
      begin
         logic [31:0] c;
         c = 32'hFFFFFFFF;
         for (int i = 0; i < 5; i++) c = crc_upd(c, rt[i].d);
         rt.push_back('{c ^ 32'hFFFFFFFF, 1'b0, 1'b1, 0});
      end
      mode_check = 1'b1;
      ln = ln + 1;
      foreach (rt[i]) put(rt[i].d, rt[i].sop, rt[i].eop, 1'b0);
      for (int i = 0; i < 5; i++) e.push_back('{rt[i].d, i == 0, i == 4, 0});
      repeat (50) @(negedge clk);
      compare(e, 1'b0, "R4", "R10");
      check(err_flag == 1'b0, "R5", "round-trip err_flag", err_flag, 0);

      // vector table
      for (int v = 0; v < NV; v++)
         run_line(VEC[v].chk, int'(VEC[v].len), VEC[v].seed, VEC[v].bad,
                  VEC[v].sof, VEC[v].stall);

      // R9 with a nonzero CRC-only beat: mismatch, sticky first line kept
      run_line(1'b1, 0, 16'h0, 1'b1, 1'b0, 1'b0);

      // R7: stall with output held, then release
      mode_check = 1'b0;
      rdy_mode   = 2;
      @(negedge clk);
      b0 = gen(16'h5A5A, 0);
      e.delete();
      fork
         begin
            for (int i = 0; i < 3; i++) put(gen(16'h5A5A, i), i == 0, i == 2, 1'b0);
         end
         begin
            repeat (2) @(negedge clk);
            for (int k = 0; k < 5; k++) begin
               #2;
               check(m_valid == 1'b1, "R7", "stalled m_valid", m_valid, 1);
               check(m_data == b0, "R7", "stalled m_data", m_data, b0);
               check(s_ready == 1'b0, "R7", "stalled s_ready", s_ready, 0);
               @(negedge clk);
            end
            rdy_mode = 0;
         end
      join
      begin
         logic [31:0] c;
         c = 32'hFFFFFFFF;
         for (int i = 0; i < 3; i++) begin
            c = crc_upd(c, gen(16'h5A5A, i));
            e.push_back('{gen(16'h5A5A, i), i == 0, 1'b0, 0});
         end
         e.push_back('{c ^ 32'hFFFFFFFF, 1'b0, 1'b1, 0});
      end
      repeat (50) @(negedge clk);
      compare(e, 1'b1, "R7", "R3");

      done = 1'b1;
      summary();
      $finish;
   end
endmodule